// File: doc/BRIEF.md
# Branch and Skip Condition Evaluator

This block resolves the control-flow outcome of a conditional relative branch or a conditional skip in a small 8-bit processor pipeline. Each accepted request carries the status register, an operation class, a flag index, a 7-bit signed displacement, the current program counter, the result of an external compare or bit test, and a hint that says whether the instruction after the current one occupies two words. One clock later the block presents the next program counter, whether the transfer was taken, and how many cycles the instruction costs.

Branches either test any single status bit, chosen by index, for set or clear, or test the signed relation N XOR V directly. Register aliases such as equal, carry, minus, half-carry and T-flag are ordinary set/clear tests on the matching bit index. Skips take the external test result and jump over the next instruction, which may be one or two words long. The comparison itself and instruction fetch are done elsewhere.

Top module: `brcond_eval`

## Requirements
- R1: While reset is asserted and after its release, out_valid, next_pc, taken and cycles are all zero until the first accepted request.
- R2: A request with in_valid high at a rising edge produces out_valid high after that edge. With in_valid low, out_valid is low after the edge and next_pc, taken and cycles keep their values whatever the other inputs do.
- R3: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7. Op code 1 branches when sreg[flag_idx] is 1; op code 2 branches when sreg[flag_idx] is 0.
- R4: Op code 3 branches when N XOR V is 0 and op code 4 branches when N XOR V is 1; the stored bit 4 has no effect on either.
- R5: A taken branch gives next_pc = pc + 1 + k, with k the 7-bit offset sign-extended; a branch not taken gives pc + 1.
- R6: A taken branch reports cycles = 2 and taken = 1; a branch not taken reports cycles = 1 and taken = 0.
- R7: Op code 5 skips when test_result is 1 and op code 6 skips when test_result is 0. A skip gives pc + 2 and cycles = 2 when next_two_word is 0, and pc + 3 and cycles = 3 when it is 1, with taken = 1.
- R8: A skip whose condition fails gives pc + 1, cycles = 1 and taken = 0, and next_two_word has no effect on it.
- R9: Op code 0 (sequential) and op code 7 (reserved) give pc + 1, cycles = 1 and taken = 0 regardless of sreg, flag_idx and test_result.
- R10: Every next_pc result wraps modulo 2^PC_W, both forwards and backwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation class code |
| flag_idx | input | 3 | Status bit index for generic branches |
| sreg | input | 8 | Status register |
| offset | input | 7 | Signed branch displacement |
| pc | input | PC_W | Program counter of the current instruction |
| test_result | input | 1 | External compare-equal or bit-test result |
| next_two_word | input | 1 | Instruction after the current one is two words |
| out_valid | output | 1 | Result strobe |
| next_pc | output | PC_W | Resolved next program counter |
| taken | output | 1 | Branch or skip was taken |
| cycles | output | 2 | Cycle cost of the instruction |

## Verification
On every cycle the assertions check the request-to-result latency, that outputs hold between requests, that any not-taken outcome lands on pc + 1 at a cost of one cycle, that taken outcomes cost at least two cycles, that branches never cost three and that a taken skip over a long instruction costs three. Which status bit a given flag index selects, the sign handling of the displacement, the independence of the signed tests from the stored S bit and the modular wrap of targets are shown only by the bench's vectors, because they depend on exact data values that no cycle-level property captures.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

    typedef enum logic [2:0] {
        OP_SEQ    = 3'd0,
        OP_BR_SET = 3'd1,
        OP_BR_CLR = 3'd2,
        OP_BR_SGE = 3'd3,
        OP_BR_SLT = 3'd4,
        OP_SKIP_T = 3'd5,
        OP_SKIP_F = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    localparam int SR_W   = 8;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;

endpackage

// File: rtl/brcond_cond_sel.sv
module brcond_cond_sel
    import brcond_pkg::*;
(
    input  op_e             op_i,
    input  logic [2:0]      flag_idx_i,
    input  logic [SR_W-1:0] sreg_i,
    input  logic            test_i,
    output logic            is_branch_o,
    output logic            is_skip_o,
    output logic            cond_met_o
);
    logic sel_bit;
    logic sign_lt;

    assign sel_bit = sreg_i[flag_idx_i];
    assign sign_lt = sreg_i[FLAG_N] ^ sreg_i[FLAG_V];

    always_comb begin
        is_branch_o = 1'b0;
        is_skip_o   = 1'b0;
        cond_met_o  = 1'b0;
        case (op_i)
            OP_BR_SET: begin is_branch_o = 1'b1; cond_met_o = sel_bit;  end
            OP_BR_CLR: begin is_branch_o = 1'b1; cond_met_o = !sel_bit; end
            OP_BR_SGE: begin is_branch_o = 1'b1; cond_met_o = !sign_lt; end
            OP_BR_SLT: begin is_branch_o = 1'b1; cond_met_o = sign_lt;  end
            OP_SKIP_T: begin is_skip_o   = 1'b1; cond_met_o = test_i;   end
            OP_SKIP_F: begin is_skip_o   = 1'b1; cond_met_o = !test_i;  end
            default:   ;
        endcase
    end
endmodule

// File: rtl/brcond_target.sv
module brcond_target #(
    parameter int PC_W  = 14,
    parameter int OFF_W = 7
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             is_branch_i,
    input  logic             is_skip_i,
    input  logic             cond_met_i,
    input  logic             two_word_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             taken_o,
    output logic [1:0]       cycles_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] pc_inc;

    assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    assign pc_inc  = pc_i + PC_W'(1);

    always_comb begin
        next_pc_o = pc_inc;
        taken_o   = 1'b0;
        cycles_o  = 2'd1;
        if (cond_met_i && is_branch_i) begin
            next_pc_o = pc_inc + off_ext;
            taken_o   = 1'b1;
            cycles_o  = 2'd2;
        end else if (cond_met_i && is_skip_i) begin
            taken_o = 1'b1;
            if (two_word_i) begin
                next_pc_o = pc_i + PC_W'(3);
                cycles_o  = 2'd3;
            end else begin
                next_pc_o = pc_i + PC_W'(2);
                cycles_o  = 2'd2;
            end
        end
    end
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
    import brcond_pkg::*;
#(
    parameter int PC_W  = 14,
    parameter int OFF_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic [2:0]       flag_idx,
    input  logic [7:0]       sreg,
    input  logic [OFF_W-1:0] offset,
    input  logic [PC_W-1:0]  pc,
    input  logic             test_result,
    input  logic             next_two_word,
    output logic             out_valid,
    output logic [PC_W-1:0]  next_pc,
    output logic             taken,
    output logic [1:0]       cycles
);
    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] npc;
        logic            taken;
        logic [1:0]      cycles;
    } res_t;

    res_t res_d, res_q;

    logic            is_branch, is_skip, cond_met;
    logic [PC_W-1:0] tgt_pc;
    logic            tgt_taken;
    logic [1:0]      tgt_cycles;

    brcond_cond_sel u_cond (
        .op_i        (op_e'(op)),
        .flag_idx_i  (flag_idx),
        .sreg_i      (sreg),
        .test_i      (test_result),
        .is_branch_o (is_branch),
        .is_skip_o   (is_skip),
        .cond_met_o  (cond_met)
    );

    brcond_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i        (pc),
        .offset_i    (offset),
        .is_branch_i (is_branch),
        .is_skip_i   (is_skip),
        .cond_met_i  (cond_met),
        .two_word_i  (next_two_word),
        .next_pc_o   (tgt_pc),
        .taken_o     (tgt_taken),
        .cycles_o    (tgt_cycles)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.npc    = tgt_pc;
            res_d.taken  = tgt_taken;
            res_d.cycles = tgt_cycles;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign next_pc   = res_q.npc;
    assign taken     = res_q.taken;
    assign cycles    = res_q.cycles;
endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      op,
    input logic [PC_W-1:0] pc,
    input logic            next_two_word,
    input logic            out_valid,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic [1:0]      cycles
);
    logic op_is_branch, op_is_skip;
    assign op_is_branch = (op >= 3'd1) && (op <= 3'd4);
    assign op_is_skip   = (op == 3'd5) || (op == 3'd6);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(next_pc) && $stable(taken) && $stable(cycles))); // R2
    AST_NOT_TAKEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (taken || next_pc == PC_W'($past(pc) + PC_W'(1)))); // R8
    AST_NOT_TAKEN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> cycles == 2'd1); // R6
    AST_TAKEN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && taken) |-> cycles >= 2'd2); // R6
    AST_BRANCH_NO_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_branch) |=> cycles != 2'd3); // R6
    AST_SKIP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_skip && next_two_word) |=> (!taken || cycles == 2'd3)); // R7
    AST_PLAIN_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_is_branch && !op_is_skip) |=> !taken); // R9
endmodule

bind brcond_eval brcond_eval_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .op            (op),
    .pc            (pc),
    .next_two_word (next_two_word),
    .out_valid     (out_valid),
    .next_pc       (next_pc),
    .taken         (taken),
    .cycles        (cycles)
);

// File: tb/brcond_eval_test.sv
module brcond_eval_test;
    localparam int PC_W = 14;
    localparam int NV   = 20;

    typedef struct packed {
        logic [2:0]      op;
        logic [2:0]      idx;
        logic [7:0]      sreg;
        logic [6:0]      k;
        logic [PC_W-1:0] pc;
        logic            tst;
        logic            two;
        logic [PC_W-1:0] e_pc;
        logic            e_tk;
        logic [1:0]      e_cy;
        logic [7:0]      req;
    } vec_t;

    // R3 generic set/clear, R4 signed, R5/R6 branch target and cost,
    // R7/R8 skips, R9 sequential/reserved, R10 wrap
    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd1, 8'h02, 7'd5,    14'h0100, 1'b0, 1'b0, 14'h0106, 1'b1, 2'd2, 8'd3},
        '{3'd1, 3'd1, 8'h00, 7'd5,    14'h0100, 1'b0, 1'b0, 14'h0101, 1'b0, 2'd1, 8'd6},
        '{3'd2, 3'd0, 8'h00, 7'h7D,   14'h0200, 1'b0, 1'b0, 14'h01FE, 1'b1, 2'd2, 8'd5},
        '{3'd2, 3'd0, 8'h01, 7'h7D,   14'h0200, 1'b0, 1'b0, 14'h0201, 1'b0, 2'd1, 8'd3},
        '{3'd1, 3'd6, 8'h40, 7'h3F,   14'h0010, 1'b0, 1'b0, 14'h0050, 1'b1, 2'd2, 8'd3},
        '{3'd3, 3'd0, 8'h0C, 7'd2,    14'h0300, 1'b0, 1'b0, 14'h0303, 1'b1, 2'd2, 8'd4},
        '{3'd3, 3'd0, 8'h14, 7'd2,    14'h0300, 1'b0, 1'b0, 14'h0301, 1'b0, 2'd1, 8'd4},
        '{3'd4, 3'd0, 8'h04, 7'h40,   14'h0300, 1'b0, 1'b0, 14'h02C1, 1'b1, 2'd2, 8'd4},
        '{3'd4, 3'd0, 8'h1C, 7'h40,   14'h0300, 1'b0, 1'b0, 14'h0301, 1'b0, 2'd1, 8'd4},
        '{3'd5, 3'd0, 8'h00, 7'd0,    14'h0400, 1'b1, 1'b0, 14'h0402, 1'b1, 2'd2, 8'd7},
        '{3'd5, 3'd0, 8'h00, 7'd0,    14'h0400, 1'b1, 1'b1, 14'h0403, 1'b1, 2'd3, 8'd7},
        '{3'd5, 3'd0, 8'h00, 7'd0,    14'h0400, 1'b0, 1'b1, 14'h0401, 1'b0, 2'd1, 8'd8},
        '{3'd6, 3'd0, 8'h00, 7'd0,    14'h0400, 1'b0, 1'b0, 14'h0402, 1'b1, 2'd2, 8'd7},
        '{3'd6, 3'd0, 8'h00, 7'd0,    14'h0400, 1'b1, 1'b1, 14'h0401, 1'b0, 2'd1, 8'd8},
        '{3'd0, 3'd1, 8'hFF, 7'd9,    14'h0500, 1'b1, 1'b1, 14'h0501, 1'b0, 2'd1, 8'd9},
        '{3'd7, 3'd1, 8'hFF, 7'd9,    14'h0500, 1'b1, 1'b1, 14'h0501, 1'b0, 2'd1, 8'd9},
        '{3'd1, 3'd7, 8'h80, 7'h3F,   14'h3FF0, 1'b0, 1'b0, 14'h0030, 1'b1, 2'd2, 8'd10},
        '{3'd2, 3'd2, 8'h00, 7'h40,   14'h0005, 1'b0, 1'b0, 14'h3FC6, 1'b1, 2'd2, 8'd10},
        '{3'd5, 3'd0, 8'h00, 7'd0,    14'h3FFE, 1'b1, 1'b1, 14'h0001, 1'b1, 2'd3, 8'd10},
        '{3'd0, 3'd0, 8'h00, 7'd0,    14'h3FFF, 1'b0, 1'b0, 14'h0000, 1'b0, 2'd1, 8'd10}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [2:0]      op = '0;
    logic [2:0]      flag_idx = '0;
    logic [7:0]      sreg = '0;
    logic [6:0]      offset = '0;
    logic [PC_W-1:0] pc = '0;
    logic            test_result = 1'b0;
    logic            next_two_word = 1'b0;
    logic            out_valid;
    logic [PC_W-1:0] next_pc;
    logic            taken;
    logic [1:0]      cycles;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    brcond_eval #(.PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .flag_idx(flag_idx), .sreg(sreg), .offset(offset), .pc(pc),
        .test_result(test_result), .next_two_word(next_two_word),
        .out_valid(out_valid), .next_pc(next_pc), .taken(taken), .cycles(cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", 32'(out_valid), 0);
        check("R1 next_pc", 32'(next_pc), 0);
        check("R1 taken/cycles", {29'd0, taken, cycles}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {16'd0, out_valid, next_pc, taken}, 0);

        for (int i = 0; i < NV; i++) begin
            op = VECS[i].op; flag_idx = VECS[i].idx; sreg = VECS[i].sreg;
            offset = VECS[i].k; pc = VECS[i].pc; test_result = VECS[i].tst;
            next_two_word = VECS[i].two; in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R%0d vec%0d valid", VECS[i].req, i), 32'(out_valid), 1);
            check($sformatf("R%0d vec%0d next_pc", VECS[i].req, i), 32'(next_pc), 32'(VECS[i].e_pc));
            check($sformatf("R%0d vec%0d taken", VECS[i].req, i), 32'(taken), 32'(VECS[i].e_tk));
            check($sformatf("R%0d vec%0d cycles", VECS[i].req, i), 32'(cycles), 32'(VECS[i].e_cy));
        end

        // R2: idle cycles hold the last result while inputs move
        op = 3'd5; flag_idx = 3'd0; sreg = 8'h00; offset = 7'd0;
        pc = 14'h0777; test_result = 1'b1; next_two_word = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R2 setup next_pc", 32'(next_pc), 32'h077A);
        in_valid = 1'b0;
        op = 3'd1; sreg = 8'hFF; pc = 14'h0123; test_result = 1'b0;
        @(negedge clk);
        check("R2 idle out_valid", 32'(out_valid), 0);
        pc = 14'h0456; op = 3'd2;
        @(negedge clk);
        check("R2 idle next_pc held", 32'(next_pc), 32'h077A);
        check("R2 idle taken/cycles held", {29'd0, taken, cycles}, {29'd0, 1'b1, 2'd3});

        // R8: failed skip ignores next_two_word
        op = 3'd6; test_result = 1'b1; next_two_word = 1'b0; pc = 14'h0010; in_valid = 1'b1;
        @(negedge clk);
        check("R8 short next_pc", 32'(next_pc), 32'h0011);
        next_two_word = 1'b1;
        @(negedge clk);
        check("R8 long next_pc", 32'(next_pc), 32'h0011);
        check("R8 long cycles", 32'(cycles), 1);

        // R1: reset mid-run clears results
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {15'd0, out_valid, next_pc, taken, cycles}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule